// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Generator

This block turns one memory request into the pin-level timing of a single machine cycle on a processor bus where the low address byte and the data byte share one set of lines. A requester presents a cycle kind (opcode fetch, memory read or memory write), a 16-bit address and a write byte. The block then steps through its T-states, one clock per T-state. It drives the upper address byte, the shared lines with their output enable, an address-latch strobe, active-low read and write strobes, and the memory/IO and two status lines.

In the first T-state the full address is on the pins and the strobe is high, so that an external latch can hold the low byte. From the second T-state on, the shared lines carry write data or are released so that memory can drive them. A read byte is taken in during the third T-state and returned with a one-clock done pulse in the cycle's final T-state. An opcode fetch adds a fourth T-state with no bus transfer, used for internal decode. While a cycle runs, the block shows busy and does not accept new requests.

Top module: `mux_bus_cycle_gen`

## Requirements
- R1: Out of reset and whenever idle: busy=0, ale=0, rd_n=1, wr_n=1, ad_oe=0, done=0, io_m=1, s1=0, s0=0, addr_hi=0. An asynchronous reset during a cycle returns all of these to their idle values at once.
- R2: Cycle kinds are coded on req_kind as 2'b00 opcode fetch, 2'b01 memory read and 2'b10 memory write. During the cycle the {io_m,s1,s0} lines read 3'b011 for a fetch, 3'b010 for a read and 3'b001 for a write.
- R3: A request accepted at a clock edge starts T1 in the following clock. Each T-state lasts one clock. A fetch lasts 4 T-states and a read or write lasts 3. busy is high in every T-state and low in the clock after the last one.
- R4: In T1, ale=1, ad_oe=1, ad_out=addr[7:0] and addr_hi=addr[15:8]. ale is low in every other T-state.
- R5: In a fetch or read, rd_n is low in T2 and T3 only, and ad_oe is low from T2 to the end of the cycle. rd_n and wr_n are never low together.
- R6: In a write, wr_n is low in T2 and T3, and ad_oe=1 with ad_out equal to the request's write byte in both. rd_n stays high.
- R7: In a read, the byte on ad_in during T3 appears on rdata in T3 together with done. In a fetch, that byte is captured at the end of T3 and appears on rdata in T4. rdata then holds the captured byte until the next fetch or read captures a new one.
- R8: T4 of a fetch drives no transfer (rd_n=1, wr_n=1, ad_oe=0), and changes on ad_in during T4 do not alter rdata.
- R9: done is a one-clock pulse in the final T-state of each cycle (T4 of a fetch, T3 of a read or write) and is low at all other times.
- R10: addr_hi and {io_m,s1,s0} stay stable from T1 to the last T-state of a cycle.
- R11: A request presented while busy is not taken: it changes neither the address, the status nor the length of the running cycle. If the request is still held, it is accepted at the first idle clock. A request with req_kind=2'b11 is never accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | Cycle kind: 00 fetch, 01 read, 10 write |
| req_addr | input | 16 | Memory address |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | Cycle in progress, requests not taken |
| done | output | 1 | Final T-state of the cycle |
| rdata | output | 8 | Byte read by the last fetch or read |
| addr_hi | output | 8 | Upper address lines |
| ad_out | output | 8 | Value driven onto the shared lines |
| ad_oe | output | 1 | Output enable for the shared lines (0 = high impedance) |
| ad_in | input | 8 | Value sensed on the shared lines |
| ale | output | 1 | Address-latch strobe, high in T1 |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| io_m | output | 1 | Memory/IO line, 0 for memory cycles |
| s1 | output | 1 | Status line 1 |
| s0 | output | 1 | Status line 0 |

## Verification
The bench goes after the fetch-versus-read split. A design that gave both kinds the same length, or reused the fetch status code for a read, would show done or s0 at the wrong T-state. It changes ad_in during the idle T4 of a fetch, which catches a design that keeps sampling the shared lines after T3 or that still drives them. A request held through a running cycle checks that the address and status lines do not jump to the new request and that the request starts only after one idle clock. A reset asserted in the middle of a write checks that the write strobe and the bus drive drop at once.

// File: rtl/mbc_pkg.sv
`timescale 1ns/1ps
package mbc_pkg;
  typedef enum logic [1:0] {
    KIND_FETCH = 2'b00,
    KIND_READ  = 2'b01,
    KIND_WRITE = 2'b10,
    KIND_NONE  = 2'b11
  } cyc_kind_e;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_T3   = 3'd3,
    TS_T4   = 3'd4
  } tstate_e;
endpackage

// File: rtl/mbc_tstate_seq.sv
`timescale 1ns/1ps
module mbc_tstate_seq
  import mbc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    is_fetch,
  output tstate_e state,
  output logic    last
);
  tstate_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TS_IDLE: if (start) state_d = TS_T1;
      TS_T1:   state_d = TS_T2;
      TS_T2:   state_d = TS_T3;
      TS_T3:   state_d = is_fetch ? TS_T4 : TS_IDLE;
      TS_T4:   state_d = TS_IDLE;
      default: state_d = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= TS_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;
  assign last  = (state_q == TS_T4) || ((state_q == TS_T3) && !is_fetch);
endmodule

// File: rtl/mbc_req_hold.sv
`timescale 1ns/1ps
module mbc_req_hold
  import mbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  cyc_kind_e         kind_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] bus_in,
  output cyc_kind_e         kind_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= KIND_FETCH;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load_en) begin
      kind_q  <= kind_in;
      addr_q  <= addr_in;
      wdata_q <= wdata_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_en) rdata_q <= bus_in;
  end
endmodule

// File: rtl/mbc_pin_ctrl.sv
`timescale 1ns/1ps
module mbc_pin_ctrl
  import mbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  tstate_e           state,
  input  cyc_kind_e         kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] rdata_q,
  input  logic [DATA_W-1:0] bus_in,
  input  logic              last,
  output logic [HI_W-1:0]   addr_hi,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              io_m,
  output logic              s1,
  output logic              s0,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  logic active, strobe_win, is_wr;

  assign active     = (state != TS_IDLE);
  assign strobe_win = (state == TS_T2) || (state == TS_T3);
  assign is_wr      = (kind == KIND_WRITE);

  always_comb begin
    addr_hi = '0;
    io_m    = 1'b1;
    s1      = 1'b0;
    s0      = 1'b0;
    if (active) begin
      addr_hi = addr[ADDR_W-1:DATA_W];
      io_m    = 1'b0;
      s1      = (kind != KIND_WRITE);
      s0      = (kind != KIND_READ);
    end
  end

  always_comb begin
    ale    = (state == TS_T1);
    ad_oe  = (state == TS_T1) || (strobe_win && is_wr);
    ad_out = '0;
    if (state == TS_T1)         ad_out = addr[DATA_W-1:0];
    else if (strobe_win && is_wr) ad_out = wdata;
    rd_n   = !(strobe_win && !is_wr);
    wr_n   = !(strobe_win && is_wr);
    done   = active && last;
    rdata  = ((state == TS_T3) && (kind == KIND_READ)) ? bus_in : rdata_q;
  end
endmodule

// File: rtl/mux_bus_cycle_gen.sv
`timescale 1ns/1ps
module mux_bus_cycle_gen
  import mbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [HI_W-1:0]   addr_hi,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_in,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              io_m,
  output logic              s1,
  output logic              s0
);
  tstate_e           state;
  cyc_kind_e         kind_in, kind_q;
  logic              start, last, cap_en;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  assign kind_in = cyc_kind_e'(req_kind);
  assign start   = req_valid && (state == TS_IDLE) && (kind_in != KIND_NONE);
  assign cap_en  = (state == TS_T3) && (kind_q != KIND_WRITE);
  assign busy    = (state != TS_IDLE);

  mbc_tstate_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .is_fetch (kind_q == KIND_FETCH),
    .state    (state),
    .last     (last)
  );

  mbc_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (start),
    .kind_in  (kind_in),
    .addr_in  (req_addr),
    .wdata_in (req_wdata),
    .cap_en   (cap_en),
    .bus_in   (ad_in),
    .kind_q   (kind_q),
    .addr_q   (addr_q),
    .wdata_q  (wdata_q),
    .rdata_q  (rdata_q)
  );

  mbc_pin_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .state   (state),
    .kind    (kind_q),
    .addr    (addr_q),
    .wdata   (wdata_q),
    .rdata_q (rdata_q),
    .bus_in  (ad_in),
    .last    (last),
    .addr_hi (addr_hi),
    .ad_out  (ad_out),
    .ad_oe   (ad_oe),
    .ale     (ale),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .io_m    (io_m),
    .s1      (s1),
    .s0      (s0),
    .done    (done),
    .rdata   (rdata)
  );
endmodule

// File: rtl/mbc_checker.sv
`timescale 1ns/1ps
module mbc_checker #(
  parameter int HI_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            ad_oe,
  input logic            ale,
  input logic            rd_n,
  input logic            wr_n,
  input logic            io_m,
  input logic            s1,
  input logic            s0,
  input logic [HI_W-1:0] addr_hi
);
  logic [2:0] tcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tcnt_q <= '0;
    else if (busy) tcnt_q <= tcnt_q + 3'd1;
    else           tcnt_q <= '0;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rd_n && wr_n && !ad_oe && !ale && !done && io_m)); // R1
  AST_MEM_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!io_m && (s1 || s0))); // R2
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R3
  AST_CYCLE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tcnt_q == ((s1 && s0) ? 3'd3 : 3'd2))); // R3
  AST_ALE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ale); // R4
  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale); // R4
  AST_RD_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (!ad_oe && wr_n)); // R5
  AST_WR_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$rose(busy)) |-> $stable({io_m, s1, s0, addr_hi})); // R10
endmodule

bind mux_bus_cycle_gen mbc_checker #(.HI_W(HI_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .done    (done),
  .ad_oe   (ad_oe),
  .ale     (ale),
  .rd_n    (rd_n),
  .wr_n    (wr_n),
  .io_m    (io_m),
  .s1      (s1),
  .s0      (s0),
  .addr_hi (addr_hi)
);

// File: tb/mux_bus_cycle_gen_test.sv
`timescale 1ns/1ps
module mux_bus_cycle_gen_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic [1:0] req_kind;
  logic [15:0] req_addr;
  logic [7:0] req_wdata, ad_in;
  logic       busy, done, ad_oe, ale, rd_n, wr_n, io_m, s1, s0;
  logic [7:0] rdata, addr_hi, ad_out;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  mux_bus_cycle_gen uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rdata(rdata), .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe),
    .ad_in(ad_in), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m),
    .s1(s1), .s0(s0)
  );

  // {kind, addr, wdata, byte on ad_in in T3}
  localparam logic [33:0] VEC [6] = '{
    {2'b00, 16'h2005, 8'h00, 8'h4F},
    {2'b01, 16'h2001, 8'h00, 8'h32},
    {2'b10, 16'h2065, 8'hA7, 8'h00},
    {2'b00, 16'hFFFF, 8'h00, 8'h00},
    {2'b01, 16'h0000, 8'h00, 8'hFF},
    {2'b10, 16'h8001, 8'h5A, 8'h00}
  };

  // ctl = {busy, ale, ad_oe, rd_n, wr_n, io_m, s1, s0, done}
  localparam logic [8:0] IDLE_CTL = 9'b0_0_0_1_1_1_0_0_0;

  function automatic logic [2:0] stat_of(input logic [1:0] k);
    case (k)
      2'b00:   return 3'b011;
      2'b01:   return 3'b010;
      default: return 3'b001;
    endcase
  endfunction

  task automatic chk_pins(input string tag, input logic [8:0] ctl,
                          input logic [7:0] hi, input logic [7:0] ad);
    logic [8:0] got;
    got = {busy, ale, ad_oe, rd_n, wr_n, io_m, s1, s0, done};
    n_tests++;
    if (got !== ctl || addr_hi !== hi || (ctl[6] && ad_out !== ad)) begin
      n_fail++;
      $display("FAIL %s: ctl=%b hi=%h ad=%h expected ctl=%b hi=%h ad=%h",
               tag, got, addr_hi, ad_out, ctl, hi, ad);
    end
  endtask

  task automatic chk_rdata(input string tag, input logic [7:0] exp);
    n_tests++;
    if (rdata !== exp) begin
      n_fail++;
      $display("FAIL %s: rdata=%h expected %h", tag, rdata, exp);
    end
  endtask

  task automatic run_cycle(input logic [1:0] k, input logic [15:0] a,
                           input logic [7:0] wd, input logic [7:0] rb);
    logic [2:0] st;
    logic       wr;
    st = stat_of(k);
    wr = (k == 2'b10);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd; ad_in = 8'h00;
    @(negedge clk);
    req_valid = 1'b0;
    chk_pins("R4 R2 T1", {1'b1, 1'b1, 1'b1, 1'b1, 1'b1, st, 1'b0}, a[15:8], a[7:0]);
    @(negedge clk);
    if (wr) chk_pins("R6 T2", {1'b1, 1'b0, 1'b1, 1'b1, 1'b0, st, 1'b0}, a[15:8], wd);
    else    chk_pins("R5 T2", {1'b1, 1'b0, 1'b0, 1'b0, 1'b1, st, 1'b0}, a[15:8], 8'h00);
    @(negedge clk);
    ad_in = rb;
    #1;
    if (wr) chk_pins("R6 R9 R10 T3", {1'b1, 1'b0, 1'b1, 1'b1, 1'b0, st, 1'b1}, a[15:8], wd);
    else    chk_pins("R5 R9 R10 T3", {1'b1, 1'b0, 1'b0, 1'b0, 1'b1, st, k == 2'b01}, a[15:8], 8'h00);
    if (k == 2'b01) chk_rdata("R7 read T3", rb);
    if (k == 2'b00) begin
      @(negedge clk);
      ad_in = ~rb;
      #1;
      chk_pins("R8 R9 T4", {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, st, 1'b1}, a[15:8], 8'h00);
      chk_rdata("R7 R8 fetch T4", rb);
    end
    @(negedge clk);
    chk_pins("R3 R1 end", IDLE_CTL, 8'h00, 8'h00);
    if (!wr) chk_rdata("R7 hold", rb);
  endtask

  initial begin
    #2_000_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'b00;
    req_addr = '0; req_wdata = '0; ad_in = '0;
    #45;
    chk_pins("R1 reset", IDLE_CTL, 8'h00, 8'h00);
    chk_rdata("R1 reset rdata", 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 6; i++)
      run_cycle(VEC[i][33:32], VEC[i][31:16], VEC[i][15:8], VEC[i][7:0]);

    // R11: invalid kind never accepted
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'b11; req_addr = 16'h1234;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk_pins("R11 kind 11 ignored", IDLE_CTL, 8'h00, 8'h00);
    end
    req_valid = 1'b0;

    // R11: request held while busy waits for idle
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'b01; req_addr = 16'h3C10; ad_in = 8'h00;
    @(negedge clk);
    req_kind = 2'b10; req_addr = 16'hD2E3; req_wdata = 8'h66;
    @(negedge clk);
    chk_pins("R11 busy T2", {1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 3'b010, 1'b0}, 8'h3C, 8'h00);
    @(negedge clk);
    chk_pins("R11 busy T3", {1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 3'b010, 1'b1}, 8'h3C, 8'h00);
    @(negedge clk);
    chk_pins("R11 R3 idle gap", IDLE_CTL, 8'h00, 8'h00);
    @(negedge clk);
    req_valid = 1'b0;
    chk_pins("R11 held request T1", {1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 3'b001, 1'b0}, 8'hD2, 8'hE3);
    @(negedge clk);
    chk_pins("R11 held request T2", {1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 3'b001, 1'b0}, 8'hD2, 8'h66);

    // R1: asynchronous reset in the middle of the write
    #3;
    rst_n = 1'b0;
    #2;
    chk_pins("R1 reset mid-cycle", IDLE_CTL, 8'h00, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_pins("R1 after reset", IDLE_CTL, 8'h00, 8'h00);

    run_cycle(2'b00, 16'h7E81, 8'h00, 8'hC3);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule